// File: doc/BRIEF.md
# Receive Packet Status Queue

This block keeps the bookkeeping for frames held in a receive buffer without storing the frame bytes themselves. The receive side marks the start of a frame, pulses once per byte that arrives, and closes the frame with an end pulse that carries a 4-bit error class. The block keeps one status entry per frame, in arrival order, and always presents the status of the oldest frame as a 16-bit word.

The host side consumes bytes of the oldest frame with single-byte read pulses and drops that frame with a discard strobe. A frame that is still arriving is shown with its partial byte count and the incomplete flag. The block also raises a receive-complete indication, a receiving flag, a full-queue flag and a sticky underrun flag that also drives the adapter-failure output. A synchronous receive-reset input returns everything to the empty state.

Top module: `rxq_top`

## Requirements
- R1: With no frame held, the status word reads 16'h8000, the queue level reads 0 and receive-complete is low.
- R2: While the oldest frame is still arriving, status bit 15 is 1, bits 14..11 are 0 and bits 10..0 hold the bytes received so far.
- R3: For a finished oldest frame, bit 15 is 0, bits 10..0 hold its byte count and bits 14..11 hold its error class when that class is one of 1000 (overrun), 1001 (oversize), 1011 (runt), 1100 (alignment) or 1101 (CRC); bit 14 is therefore 1 only for these five classes.
- R4: A finished frame closed with class 0010 (dribble bits) reports 0010 in bits 14..11; every other class outside the five error classes reports 0000.
- R5: The byte count stops at 1514; a frame that receives more than 1514 bytes reports a count of 1514 and class 1001, whatever class its end pulse carried.
- R6: The queue holds at most 8 frames, counting one that is still arriving. While 8 are held the overrun flag is 1 and a frame-start pulse is ignored together with its bytes and end pulse; the flag drops once a frame is discarded.
- R7: A read pulse when the queue is empty, or when the bytes already read from the oldest frame equal the bytes received for it, sets the underrun flag and adapter failure; both stay set until receive reset. Reads within the received count never set it.
- R8: A discard strobe removes a finished oldest frame whether or not its bytes were read, and the next frame is read from its first byte; a discard while the oldest frame is still arriving, or while empty, changes nothing.
- R9: Receive-complete is 1 exactly when the oldest frame held has been finished.
- R10: A receive-reset pulse empties the queue and clears the receiving, overrun and underrun flags by the next cycle.
- R11: Frames are reported in the order their start pulses were accepted.
- R12: The receiving flag is 1 from an accepted frame-start pulse until the matching end pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| rxReset | input | 1 | Synchronous receive reset, empties the queue |
| pktStart | input | 1 | Frame-start pulse from the receive side |
| byteRecv | input | 1 | One byte of the current frame arrived |
| pktEnd | input | 1 | Frame-end pulse, qualifies errClass |
| errClass | input | 4 | Error class of the frame being closed |
| rdData | input | 1 | Host consumes one byte of the oldest frame |
| discardTop | input | 1 | Host drops the oldest frame |
| statusWord | output | CNT_W+5 | Status of the oldest frame |
| rxComplete | output | 1 | Oldest frame is finished |
| receiving | output | 1 | A frame is being written |
| statusOverrun | output | 1 | Queue holds its maximum number of frames |
| rxUnderrun | output | 1 | Sticky read-past-end flag |
| adapterFail | output | 1 | Adapter failure, raised by underrun |
| queueLevel | output | $clog2(DEPTH+1) | Number of frames held |

## Verification
The bench sweeps all sixteen end classes, so a design that let a non-error class with bit 3 set leak into the field, or dropped the dribble class, reports a wrong word. It feeds exactly 1514 and then 1515 bytes: an off-by-one limit either wraps the count or flags a legal frame as oversize. It fills the queue to eight and sends a ninth frame, which a design with a wrong limit would accept or count, and it reads exactly up to and one past the received count, including on a frame still arriving, where a design comparing against the wrong bound raises underrun too early or never. Discards of an incomplete or empty top and a read after a partly read frame is dropped catch a queue that pops the wrong entry or keeps a stale read position.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  localparam int CODE_W = 4;

  // Strobes issued by the control to the datapath, one cycle each.
  typedef struct packed {
    logic flush;     // empty everything
    logic alloc;     // open a new entry at the tail
    logic byteAdd;   // one more byte for the open entry
    logic close;     // finish the open entry
    logic pop;       // drop the head entry
    logic readAdv;   // host consumed one byte of the head entry
  } rxqStrobes_t;

  // Map the class carried by the end pulse onto the reported field.
  function automatic logic [CODE_W-1:0] classifyCode(input logic [CODE_W-1:0] raw,
                                                     input logic tooLong);
    logic [CODE_W-1:0] res;
    if (tooLong) begin
      res = 4'b1001;
    end else begin
      case (raw)
        4'b1000, 4'b1001, 4'b1011,
        4'b1100, 4'b1101, 4'b0010: res = raw;
        default:                   res = 4'b0000;
      endcase
    end
    return res;
  endfunction

endpackage

// File: rtl/rxq_datapath.sv
module rxq_datapath
  import rxq_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int CNT_W   = 11,
  parameter int MAX_LEN = 1514
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  rxqStrobes_t                  st,
  input  logic [CODE_W-1:0]            errClass,
  output logic [$clog2(DEPTH+1)-1:0]   level,
  output logic                         topDone,
  output logic                         readInRange,
  output logic [CNT_W+CODE_W:0]        statusWord
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [PTR_W-1:0] PTR_ONE  = PTR_W'(1);
  localparam logic [LVL_W-1:0] LVL_ONE  = LVL_W'(1);
  localparam logic [CNT_W-1:0] LEN_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] LEN_MAX  = CNT_W'(MAX_LEN);

  logic [PTR_W-1:0]  hdPtr, tlPtr, curPtr;
  logic [CNT_W-1:0]  rdPos;
  logic              tooLong;
  logic              doneQ [DEPTH];
  logic [CODE_W-1:0] codeQ [DEPTH];
  logic [CNT_W-1:0]  lenQ  [DEPTH];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + PTR_ONE;
  endfunction

  // Oversize detection for the open entry, including a byte arriving with the end pulse.
  logic longNow;
  assign longNow = tooLong | (st.byteAdd && lenQ[curPtr] == LEN_MAX);

  // One storage slot per queue position.
  for (genvar gi = 0; gi < DEPTH; gi++) begin : gSlot
    localparam logic [PTR_W-1:0] IDX = PTR_W'(gi);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        doneQ[gi] <= 1'b0;
        codeQ[gi] <= '0;
        lenQ[gi]  <= '0;
      end else if (st.flush) begin
        doneQ[gi] <= 1'b0;
        codeQ[gi] <= '0;
        lenQ[gi]  <= '0;
      end else if (st.alloc && tlPtr == IDX) begin
        doneQ[gi] <= 1'b0;
        codeQ[gi] <= '0;
        lenQ[gi]  <= '0;
      end else if (curPtr == IDX) begin
        if (st.byteAdd && lenQ[gi] != LEN_MAX) lenQ[gi] <= lenQ[gi] + LEN_ONE;
        if (st.close) begin
          doneQ[gi] <= 1'b1;
          codeQ[gi] <= classifyCode(errClass, longNow);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hdPtr   <= '0;
      tlPtr   <= '0;
      curPtr  <= '0;
      level   <= '0;
      rdPos   <= '0;
      tooLong <= 1'b0;
    end else if (st.flush) begin
      hdPtr   <= '0;
      tlPtr   <= '0;
      curPtr  <= '0;
      level   <= '0;
      rdPos   <= '0;
      tooLong <= 1'b0;
    end else begin
      if (st.alloc) begin
        curPtr  <= tlPtr;
        tlPtr   <= nextPtr(tlPtr);
        tooLong <= 1'b0;
      end else if (st.byteAdd && lenQ[curPtr] == LEN_MAX) begin
        tooLong <= 1'b1;
      end
      if (st.pop) begin
        hdPtr <= nextPtr(hdPtr);
        rdPos <= '0;
      end else if (st.readAdv) begin
        rdPos <= rdPos + LEN_ONE;
      end
      case ({st.alloc, st.pop})
        2'b10:   level <= level + LVL_ONE;
        2'b01:   level <= level - LVL_ONE;
        default: level <= level;
      endcase
    end
  end

  logic notEmpty;
  assign notEmpty    = (level != '0);
  assign topDone     = notEmpty && doneQ[hdPtr];
  assign readInRange = notEmpty && (rdPos < lenQ[hdPtr]);

  always_comb begin
    if (!notEmpty)      statusWord = {1'b1, {(CODE_W+CNT_W){1'b0}}};
    else if (!topDone)  statusWord = {1'b1, {CODE_W{1'b0}}, lenQ[hdPtr]};
    else                statusWord = {1'b0, codeQ[hdPtr], lenQ[hdPtr]};
  end

endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       rxReset,
  input  logic                       pktStart,
  input  logic                       byteRecv,
  input  logic                       pktEnd,
  input  logic                       rdData,
  input  logic                       discardTop,
  input  logic [$clog2(DEPTH+1)-1:0] level,
  input  logic                       topDone,
  input  logic                       readInRange,
  output rxqStrobes_t                st,
  output logic                       receiving,
  output logic                       statusOverrun,
  output logic                       rxUnderrun
);

  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(DEPTH);

  logic isFull;
  assign isFull = (level == LVL_FULL);

  always_comb begin
    st         = '0;
    st.flush   = rxReset;
    if (!rxReset) begin
      st.alloc   = pktStart && !receiving && !isFull;
      st.byteAdd = byteRecv && receiving;
      st.close   = pktEnd && receiving;
      st.pop     = discardTop && topDone;
      st.readAdv = rdData && readInRange;
    end
  end

  logic badRead;
  assign badRead = !rxReset && rdData && !readInRange;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      receiving  <= 1'b0;
      rxUnderrun <= 1'b0;
    end else if (rxReset) begin
      receiving  <= 1'b0;
      rxUnderrun <= 1'b0;
    end else begin
      if (st.alloc)      receiving <= 1'b1;
      else if (st.close) receiving <= 1'b0;
      if (badRead) rxUnderrun <= 1'b1;
    end
  end

  assign statusOverrun = isFull;

endmodule

// File: rtl/rxq_top.sv
module rxq_top
  import rxq_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int CNT_W   = 11,
  parameter int MAX_LEN = 1514
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       rxReset,
  input  logic                       pktStart,
  input  logic                       byteRecv,
  input  logic                       pktEnd,
  input  logic [3:0]                 errClass,
  input  logic                       rdData,
  input  logic                       discardTop,
  output logic [CNT_W+4:0]           statusWord,
  output logic                       rxComplete,
  output logic                       receiving,
  output logic                       statusOverrun,
  output logic                       rxUnderrun,
  output logic                       adapterFail,
  output logic [$clog2(DEPTH+1)-1:0] queueLevel
);

  rxqStrobes_t st;
  logic        topDone;
  logic        readInRange;

  rxq_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .rxReset(rxReset),
    .pktStart(pktStart), .byteRecv(byteRecv), .pktEnd(pktEnd),
    .rdData(rdData), .discardTop(discardTop),
    .level(queueLevel), .topDone(topDone), .readInRange(readInRange),
    .st(st), .receiving(receiving), .statusOverrun(statusOverrun),
    .rxUnderrun(rxUnderrun)
  );

  rxq_datapath #(.DEPTH(DEPTH), .CNT_W(CNT_W), .MAX_LEN(MAX_LEN)) uPath (
    .clk(clk), .rstN(rstN), .st(st), .errClass(errClass),
    .level(queueLevel), .topDone(topDone), .readInRange(readInRange),
    .statusWord(statusWord)
  );

  assign rxComplete  = topDone;
  assign adapterFail = rxUnderrun;

endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 11
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       rxReset,
  input logic                       pktStart,
  input logic                       rdData,
  input logic [CNT_W+4:0]           statusWord,
  input logic                       rxComplete,
  input logic                       receiving,
  input logic                       statusOverrun,
  input logic                       rxUnderrun,
  input logic                       adapterFail,
  input logic [$clog2(DEPTH+1)-1:0] queueLevel
);

  localparam int LVL_W = $clog2(DEPTH + 1);

  // R1
  empty_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    queueLevel == '0 |-> (statusWord == {1'b1, {(CNT_W+4){1'b0}}} && !rxComplete));

  // R9
  complete_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxComplete |-> !statusWord[CNT_W+4]);

  // R6
  full_start_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusOverrun && pktStart && !receiving && !rxReset) |=> (!receiving && queueLevel == LVL_W'(DEPTH)));

  // R6
  level_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    queueLevel <= LVL_W'(DEPTH));

  // R7
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxUnderrun && !rxReset) |=> rxUnderrun);

  // R7
  empty_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (queueLevel == '0 && rdData && !rxReset) |=> (rxUnderrun && adapterFail));

  // R10
  rx_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxReset |=> (queueLevel == '0 && !rxUnderrun && !receiving && !statusOverrun));

  // R2
  arriving_top_chk: assert property (@(posedge clk) disable iff (!rstN)
    (receiving && queueLevel == LVL_W'(1)) |-> (statusWord[CNT_W+4] && !rxComplete));

endmodule

bind rxq_top rxq_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .rxReset(rxReset), .pktStart(pktStart), .rdData(rdData),
  .statusWord(statusWord), .rxComplete(rxComplete), .receiving(receiving),
  .statusOverrun(statusOverrun), .rxUnderrun(rxUnderrun),
  .adapterFail(adapterFail), .queueLevel(queueLevel)
);

// File: tb/tb_rxq_top.sv
module tb_rxq_top;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 8;
  localparam int CNT_W      = 11;
  localparam int MAX_LEN    = 1514;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxReset = 1'b0, pktStart = 1'b0, byteRecv = 1'b0, pktEnd = 1'b0;
  logic [3:0]  errClass = '0;
  logic        rdData = 1'b0, discardTop = 1'b0;
  logic [15:0] statusWord;
  logic        rxComplete, receiving, statusOverrun, rxUnderrun, adapterFail;
  logic [3:0]  queueLevel;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxq_top #(.DEPTH(DEPTH), .CNT_W(CNT_W), .MAX_LEN(MAX_LEN)) dut (
    .clk(clk), .rstN(rstN), .rxReset(rxReset), .pktStart(pktStart),
    .byteRecv(byteRecv), .pktEnd(pktEnd), .errClass(errClass),
    .rdData(rdData), .discardTop(discardTop), .statusWord(statusWord),
    .rxComplete(rxComplete), .receiving(receiving), .statusOverrun(statusOverrun),
    .rxUnderrun(rxUnderrun), .adapterFail(adapterFail), .queueLevel(queueLevel)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] expCode(input logic [3:0] c, input bit long);
    if (long) return 4'd9;
    if (c == 4'd8 || c == 4'd9 || c == 4'd11 || c == 4'd12 || c == 4'd13 || c == 4'd2) return c;
    return 4'd0;
  endfunction

  function automatic logic [15:0] doneWord(input logic [3:0] c, input int len, input bit long);
    int l = (len > MAX_LEN) ? MAX_LEN : len;
    return {1'b0, expCode(c, long), 11'(l)};
  endfunction

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
  endtask

  task automatic sendBytes(input int n);
    if (n > 0) begin
      @(negedge clk); byteRecv = 1'b1;
      repeat (n) @(negedge clk);
      byteRecv = 1'b0;
    end
  endtask

  task automatic readBytes(input int n);
    if (n > 0) begin
      @(negedge clk); rdData = 1'b1;
      repeat (n) @(negedge clk);
      rdData = 1'b0;
    end
  endtask

  task automatic endPkt(input logic [3:0] c);
    @(negedge clk); pktEnd = 1'b1; errClass = c;
    @(negedge clk); pktEnd = 1'b0; errClass = '0;
  endtask

  task automatic fullPkt(input int n, input logic [3:0] c);
    pulse(pktStart);
    sendBytes(n);
    endPkt(c);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 status", statusWord, 16'h8000);
    check("R1 level", queueLevel, 0);
    check("R9 complete idle", rxComplete, 0);
    check("R12 receiving idle", receiving, 0);
    check("R7 underrun idle", rxUnderrun, 0);

    // R2 R12 arriving frame with partial count
    pulse(pktStart);
    check("R12 receiving after start", receiving, 1);
    check("R2 empty partial", statusWord, 16'h8000);
    sendBytes(5);
    check("R2 partial count", statusWord, 16'h8005);
    check("R9 complete while arriving", rxComplete, 0);
    // R8 discard ignored on arriving top
    pulse(discardTop);
    check("R8 discard arriving", {28'd0, queueLevel}, 1);
    check("R8 discard arriving word", statusWord, 16'h8005);
    // R7 read within partial count, then one past it
    readBytes(5);
    check("R7 reads in range", rxUnderrun, 0);
    pulse(rdData);
    check("R7 read past partial", rxUnderrun, 1);
    check("R7 adapter fail", adapterFail, 1);
    sendBytes(2);
    endPkt(4'd0);
    check("R7 sticky", rxUnderrun, 1);
    check("R12 receiving after end", receiving, 0);
    // R10 receive reset
    pulse(rxReset);
    check("R10 level", queueLevel, 0);
    check("R10 status", statusWord, 16'h8000);
    check("R10 underrun", rxUnderrun, 0);
    check("R10 adapter", adapterFail, 0);

    // R3 R4 R9 R8 sweep of every end class
    for (int c = 0; c < 16; c++) begin
      int n = c * 7 + 3;
      fullPkt(n, 4'(c));
      check($sformatf("R3 R4 class %0d", c), statusWord, doneWord(4'(c), n, 0));
      check("R9 complete when finished", rxComplete, 1);
      check("R3 error bit", statusWord[14],
            (c == 8 || c == 9 || c == 11 || c == 12 || c == 13) ? 1 : 0);
      pulse(discardTop);
      check("R8 discard unread", statusWord, 16'h8000);
    end

    // R8 discard when empty
    pulse(discardTop);
    check("R8 discard empty", queueLevel, 0);

    // R5 boundary lengths
    fullPkt(MAX_LEN, 4'd0);
    check("R5 exact limit", statusWord, doneWord(4'd0, MAX_LEN, 0));
    pulse(discardTop);
    fullPkt(MAX_LEN + 1, 4'd13);
    check("R5 over limit", statusWord, doneWord(4'd13, MAX_LEN + 1, 1));
    pulse(discardTop);

    // R6 R11 fill the queue
    for (int i = 0; i < DEPTH; i++) begin
      check("R6 not full yet", statusOverrun, 0);
      fullPkt(i + 1, 4'd12);
    end
    check("R6 full level", queueLevel, DEPTH);
    check("R6 overrun flag", statusOverrun, 1);
    pulse(pktStart);
    check("R6 start ignored", receiving, 0);
    sendBytes(4);
    endPkt(4'd8);
    check("R6 level unchanged", queueLevel, DEPTH);
    check("R11 head first", statusWord, doneWord(4'd12, 1, 0));
    for (int i = 0; i < DEPTH; i++) begin
      check($sformatf("R11 order %0d", i), statusWord, doneWord(4'd12, i + 1, 0));
      pulse(discardTop);
      check("R6 overrun cleared", statusOverrun, 0);
    end
    check("R6 drained", queueLevel, 0);

    // R8 R7 read position restarts after a discard
    fullPkt(4, 4'd0);
    fullPkt(3, 4'd2);
    readBytes(2);
    pulse(discardTop);
    check("R11 second frame", statusWord, doneWord(4'd2, 3, 0));
    readBytes(3);
    check("R8 read restarted", rxUnderrun, 0);
    pulse(rdData);
    check("R7 read past finished", rxUnderrun, 1);
    pulse(rxReset);
    pulse(rdData);
    check("R7 read when empty", rxUnderrun, 1);
    pulse(rxReset);
    check("R10 clear again", rxUnderrun, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule